// File: doc/BRIEF.md
# Delta-Cycle Scheduler with Double-Buffered State Memory

This block is the controller of a sequential hardware simulator. One shared copy of a cell's combinational logic stands in for N identical cells. The logic sits outside this block, as does the storage for the links between cells. Simulated time moves in system cycles. Each system cycle is built from delta cycles, and each delta cycle evaluates exactly one cell. In that delta cycle the controller presents the cell's index, reads the cell's current state from an internal memory and offers it to the shared logic. It then writes the returned next state into the other half of the memory.

The order of evaluation is decided at run time. Each cell carries a stable flag. All flags are cleared when a system cycle begins. Evaluating a cell sets its own flag. The external link storage reports which cells saw an input link change value during that evaluation, and those cells lose their flag again. A round-robin picker chooses the next cell from those that are not stable. When every cell is stable, the system cycle closes in one extra clock: a bank-select bit flips, so the freshly written half becomes the current half without any copying. The cycle counter then advances. A run starts on a pulse and proceeds until a target number of system cycles is complete. A per-cycle limit on delta cycles stops a run that never settles and raises an error flag.

Top module: `delta_sched`

## Requirements
- R1: After reset, eval_valid, done and err are 0, busy is 0, sys_count is 0 and bank_sel is 0. Every state word is 0, so each cell's first current state reads as 0.
- R2: A start pulse while no run is active loads the target, clears sys_count and clears every stable flag. Each system cycle then evaluates every cell at least once.
- R3: The first cell granted in each system cycle is the lowest-numbered non-stable cell, which is cell 0. Each later grant goes to the first non-stable cell found by counting upward from the last granted cell and wrapping from N-1 to 0.
- R4: An evaluated cell becomes stable unless its own bit is set in wake_in in that same clock. Bit k of wake_in during any evaluation makes cell k non-stable, whether or not it was already evaluated.
- R5: During an evaluation, rd_addr is {bank_sel, eval_cell} and wr_addr is {~bank_sel, eval_cell}, with the bank bit as the MSB. cur_state is the word at rd_addr, and new_state is stored at wr_addr. A cell evaluated twice in one system cycle reads the same current state both times.
- R6: In a clock of a run where no cell is non-stable, no evaluation happens. In that clock bank_sel toggles, sys_count increments and all stable flags clear. The states written in the cycle that just closed become the current states of the next cycle.
- R7: done rises in the clock after the system cycle that brings sys_count to the target. A target of 0 raises done in the clock after start, with no evaluation.
- R8: If DLIM evaluations have been made in one system cycle and a cell is still non-stable, err rises and evaluation stops. bank_sel and sys_count keep their values, and the current states stay those of the last completed system cycle.
- R9: done and err hold, with no evaluation, until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (ignored while a run is active) |
| target_cycles | input | CNTW | Number of system cycles to simulate, sampled at start |
| wake_in | input | N | Cells whose input links changed during this evaluation |
| new_state | input | SW | Next state computed by the shared cell logic |
| eval_valid | output | 1 | A cell is being evaluated in this clock |
| eval_cell | output | CW | Index of the cell being evaluated |
| rd_addr | output | CW+1 | State memory read address (current half) |
| wr_addr | output | CW+1 | State memory write address (new half) |
| cur_state | output | SW | Current state of the evaluated cell |
| bank_sel | output | 1 | Which half holds current states |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run completed its target |
| err | output | 1 | Run stopped at the delta-cycle limit |
| sys_count | output | CNTW | System cycles completed in this run |

## Verification
A wrong stable flag or round-robin pointer changes the order of eval_cell in the very delta cycle it goes wrong. The scoreboard compares every grant against a precomputed order, so such a fault shows immediately. A bank-select or write-address fault leaves the evaluation order intact, but the next system cycle then reads a stale or foreign word on cur_state. That appears at most one system cycle later, and the checks hit it hardest after a re-evaluation and after an aborted run. A miscounted delta limit or cycle counter moves the clock in which err or done rises, and each run's end flags and count are checked.

// File: rtl/delta_sched_pkg.sv
// Shared types for the delta-cycle scheduler.
package delta_sched_pkg;
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_RUN  = 2'd1,
        RS_DONE = 2'd2,
        RS_ERR  = 2'd3
    } run_state_t;
endpackage

// File: rtl/rr_pick.sv
// Round-robin picker: finds the first pending cell strictly after ptr,
// counting upward and wrapping. Assumes ptr < N.
module rr_pick #(
    parameter int N  = 4,
    parameter int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pend,
    input  logic [CW-1:0] ptr,
    output logic          any,
    output logic [CW-1:0] grant
);
    // Scan N positions starting after ptr; keep the first hit.
    always_comb begin
        any   = 1'b0;
        grant = '0;
        for (int i = 1; i <= N; i++) begin
            int j;
            j = (int'(ptr) + i) % N;
            if (!any && pend[j]) begin
                any   = 1'b1;
                grant = CW'(j);
            end
        end
    end

    // R3: a grant always names a pending cell
    always_comb begin
        a_r3_grant_pending: assert (!any || pend[grant]);
    end
endmodule

// File: rtl/state_mem.sv
// Two-bank state memory: asynchronous read, synchronous write.
// The bank bit is the address MSB. Reset clears every word.
module state_mem #(
    parameter int SW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [SW-1:0] wr_data,
    output logic [SW-1:0] rd_data
);
    localparam int DEPTH = 2 ** AW;

    logic [SW-1:0] mem [DEPTH];

    // Store one word per evaluation; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Combinational read for same-clock evaluation.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/delta_sched.sv
// Delta-cycle scheduler. It evaluates one non-stable cell per clock through
// external shared logic and closes a system cycle when all cells are stable
// by flipping the bank select. Assumes wake_in is valid with eval_valid.
module delta_sched
    import delta_sched_pkg::*;
#(
    parameter int N    = 4,
    parameter int SW   = 8,
    parameter int CNTW = 16,
    parameter int DLIM = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNTW-1:0]   target_cycles,
    input  logic [N-1:0]      wake_in,
    input  logic [SW-1:0]     new_state,
    output logic              eval_valid,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] eval_cell,
    output logic [((N > 1) ? $clog2(N) : 1):0]   rd_addr,
    output logic [((N > 1) ? $clog2(N) : 1):0]   wr_addr,
    output logic [SW-1:0]     cur_state,
    output logic              bank_sel,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [CNTW-1:0]   sys_count
);
    localparam int CW  = (N > 1) ? $clog2(N) : 1;
    localparam int AW  = CW + 1;
    localparam int DCW = $clog2(DLIM + 1);
    localparam logic [CW-1:0] PTR_INIT = CW'(N - 1);

    run_state_t      st_q;
    logic [N-1:0]    stable_q;
    logic [CW-1:0]   ptr_q;
    logic [DCW-1:0]  dcnt_q;
    logic [CNTW-1:0] tgt_q;
    logic            bank_q;
    logic            any_pend;
    logic [CW-1:0]   pick;
    logic [N-1:0]    pick_bit;
    logic            at_limit;

    rr_pick #(.N(N), .CW(CW)) u_pick (
        .pend  (~stable_q),
        .ptr   (ptr_q),
        .any   (any_pend),
        .grant (pick)
    );

    state_mem #(.SW(SW), .AW(AW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .wr_en   (eval_valid),
        .wr_addr (wr_addr),
        .wr_data (new_state),
        .rd_data (cur_state)
    );

    // Evaluation handshake and addressing toward the shared logic.
    assign at_limit   = (dcnt_q == DCW'(DLIM));
    assign eval_valid = (st_q == RS_RUN) && any_pend && !at_limit;
    assign eval_cell  = pick;
    assign rd_addr    = {bank_q, pick};
    assign wr_addr    = {~bank_q, pick};
    assign pick_bit   = {{(N-1){1'b0}}, 1'b1} << pick;
    assign bank_sel   = bank_q;
    assign busy       = (st_q == RS_RUN);
    assign done       = (st_q == RS_DONE);
    assign err        = (st_q == RS_ERR);

    // Run control: start, delta evaluation, system-cycle close, limit abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= RS_IDLE;
            stable_q  <= '0;
            ptr_q     <= PTR_INIT;
            dcnt_q    <= '0;
            tgt_q     <= '0;
            bank_q    <= 1'b0;
            sys_count <= '0;
        end else if (st_q != RS_RUN) begin
            if (start) begin
                tgt_q     <= target_cycles;
                sys_count <= '0;
                stable_q  <= '0;
                ptr_q     <= PTR_INIT;
                dcnt_q    <= '0;
                st_q      <= (target_cycles == '0) ? RS_DONE : RS_RUN;
            end
        end else if (eval_valid) begin
            stable_q <= (stable_q | pick_bit) & ~wake_in;
            ptr_q    <= pick;
            dcnt_q   <= dcnt_q + DCW'(1);
        end else if (any_pend) begin
            st_q <= RS_ERR;
        end else begin
            bank_q    <= ~bank_q;
            sys_count <= sys_count + CNTW'(1);
            stable_q  <= '0;
            ptr_q     <= PTR_INIT;
            dcnt_q    <= '0;
            if (sys_count + CNTW'(1) == tgt_q) st_q <= RS_DONE;
        end
    end

    // R4: the evaluated cell was non-stable
    a_r4_pick_unstable: assert property (@(posedge clk) disable iff (!rst_n)
        eval_valid |-> !stable_q[eval_cell]);

    // R6: closing a system cycle flips the bank
    a_r6_bank_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_RUN && !any_pend) |=> (bank_sel != $past(bank_sel)));

    // R7: a finished run has met its target
    a_r7_done_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sys_count == tgt_q));

    // R8: pending work at the limit aborts the run
    a_r8_limit_err: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_RUN && any_pend && at_limit) |=> err);

    // R9: no evaluation outside a run
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !eval_valid);
endmodule

// File: tb/delta_sched_test.sv
`timescale 1ns/1ps
module delta_sched_test;
    localparam int N = 4;
    localparam int SW = 8;
    localparam int CNTW = 16;
    localparam int DLIM = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [CNTW-1:0] target_cycles = '0;
    logic [N-1:0]    wake_in;
    logic [SW-1:0]   new_state;
    logic            eval_valid;
    logic [1:0]      eval_cell;
    logic [2:0]      rd_addr, wr_addr;
    logic [SW-1:0]   cur_state;
    logic            bank_sel, busy, done, err;
    logic [CNTW-1:0] sys_count;

    int n_checks = 0;
    int n_fail = 0;
    int n_evals = 0;
    int wdog = 0;

    int  wake_mode = 0;      // 0 none, 1 one-shot src->dst, 2 wake all
    int  wake_src = 0, wake_dst = 0;
    bit  fired = 0;
    int  exp_cell[$];
    int  exp_st[$];
    logic [SW-1:0] model [N];

    always #4 clk = ~clk;

    delta_sched #(.N(N), .SW(SW), .CNTW(CNTW), .DLIM(DLIM)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .target_cycles(target_cycles),
        .wake_in(wake_in), .new_state(new_state), .eval_valid(eval_valid),
        .eval_cell(eval_cell), .rd_addr(rd_addr), .wr_addr(wr_addr),
        .cur_state(cur_state), .bank_sel(bank_sel), .busy(busy), .done(done),
        .err(err), .sys_count(sys_count)
    );

    // Stand-in shared cell logic and link-change reporting.
    assign new_state = cur_state + SW'(eval_cell) + SW'(1);
    assign wake_in = !eval_valid ? '0 :
                     (wake_mode == 2) ? '1 :
                     (wake_mode == 1 && !fired && int'(eval_cell) == wake_src)
                         ? N'(1 << wake_dst) : '0;

    always @(posedge clk)
        if (wake_mode == 1 && eval_valid && int'(eval_cell) == wake_src) fired <= 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver side: queue one system cycle's expected grants, then advance model.
    task automatic plan(input int cells[$]);
        bit seen [N];
        foreach (cells[i]) begin
            exp_cell.push_back(cells[i]);
            exp_st.push_back(int'(model[cells[i]]));
        end
        foreach (cells[i]) seen[cells[i]] = 1;
        for (int c = 0; c < N; c++)
            if (seen[c]) model[c] = model[c] + SW'(c) + SW'(1);
    endtask

    // Monitor: compare each evaluation against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && eval_valid) begin
            n_evals++;
            if (exp_cell.size() == 0) begin
                chk(0, "R9", "unexpected evaluation of cell", int'(eval_cell), -1);
            end else begin
                int ec, es;
                ec = exp_cell.pop_front();
                es = exp_st.pop_front();
                chk(int'(eval_cell) == ec, "R3", "granted cell", int'(eval_cell), ec);
                chk(int'(cur_state) == es, "R5", "current state read", int'(cur_state), es);
            end
            chk(rd_addr == {bank_sel, eval_cell}, "R5", "read address", int'(rd_addr),
                int'({bank_sel, eval_cell}));
            chk(wr_addr == {~bank_sel, eval_cell}, "R5", "write address", int'(wr_addr),
                int'({~bank_sel, eval_cell}));
        end
    end

    // Watchdog: a hung run is a failure.
    always @(posedge clk) begin
        wdog++;
        if (wdog > 100000) begin
            chk(0, "R7", "watchdog expired", wdog, 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic run(input int tgt, input int mode, input int src, input int dst);
        int guard = 0;
        @(negedge clk);
        wake_mode = mode; wake_src = src; wake_dst = dst; fired = 0;
        n_evals = 0;
        target_cycles = CNTW'(tgt);
        start = 1;
        @(negedge clk);
        start = 0;
        while (!(done || err) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 2000, "R7", "run finished", guard, 2000);
    endtask

    initial begin
        for (int c = 0; c < N; c++) model[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!eval_valid && !done && !err && !busy, "R1", "idle flags", int'({eval_valid, done, err, busy}), 0);
        chk(sys_count == 0, "R1", "sys_count", int'(sys_count), 0);
        chk(bank_sel == 0, "R1", "bank_sel", int'(bank_sel), 0);

        // R7: zero target finishes at once
        run(0, 0, 0, 0);
        chk(done && !err, "R7", "done on zero target", int'(done), 1);
        chk(n_evals == 0, "R7", "evaluations on zero target", n_evals, 0);

        // R2, R6: two quiet system cycles, states start at zero
        plan('{0, 1, 2, 3});
        plan('{0, 1, 2, 3});
        run(2, 0, 0, 0);
        chk(done, "R7", "done after two cycles", int'(done), 1);
        chk(sys_count == 2, "R6", "sys_count after two cycles", int'(sys_count), 2);
        chk(bank_sel == 0, "R6", "bank after two flips", int'(bank_sel), 0);
        chk(n_evals == 8, "R2", "evaluations in two cycles", n_evals, 8);
        chk(exp_cell.size() == 0, "R2", "scoreboard drained", exp_cell.size(), 0);
        // R9: done holds with no evaluation
        repeat (3) @(negedge clk);
        chk(done && !busy, "R9", "done held", int'(done), 1);

        // R4, R3: cell 2 wakes cell 0 that was already evaluated
        plan('{0, 1, 2, 3, 0});
        run(1, 1, 2, 0);
        chk(n_evals == 5, "R4", "re-evaluation count", n_evals, 5);
        chk(bank_sel == 1, "R6", "bank after one flip", int'(bank_sel), 1);
        chk(sys_count == 1, "R6", "sys_count", int'(sys_count), 1);

        // R4: cell 1 wakes itself, revisited after the wrap
        plan('{0, 1, 2, 3, 1});
        run(1, 1, 1, 1);
        chk(n_evals == 5, "R4", "self-wake evaluation count", n_evals, 5);
        chk(bank_sel == 0, "R6", "bank after self-wake run", int'(bank_sel), 0);

        // R8: never settles, aborts at the delta limit; model not advanced
        for (int k = 0; k < DLIM / N; k++)
            for (int c = 0; c < N; c++) begin
                exp_cell.push_back(c);
                exp_st.push_back(int'(model[c]));
            end
        run(3, 2, 0, 0);
        chk(err && !done, "R8", "err at limit", int'(err), 1);
        chk(n_evals == DLIM, "R8", "evaluations before abort", n_evals, DLIM);
        chk(bank_sel == 0, "R8", "bank kept", int'(bank_sel), 0);
        chk(sys_count == 0, "R8", "sys_count kept", int'(sys_count), 0);
        repeat (3) @(negedge clk);
        chk(err, "R9", "err held", int'(err), 1);

        // R8, R5: after abort, current states are the last completed ones
        plan('{0, 1, 2, 3});
        run(1, 0, 0, 0);
        chk(done && !err, "R9", "new start clears err", int'(err), 0);
        chk(bank_sel == 1, "R6", "bank after recovery", int'(bank_sel), 1);
        chk(exp_cell.size() == 0, "R2", "scoreboard drained", exp_cell.size(), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule